// File: doc/BRIEF.md
# Prescaled Pacer Clock Generator

This block paces the conversions of a data-acquisition front end. It runs on the fixed base oscillator clock (one clock cycle is the 250 ns base period of a 4 MHz oscillator) and divides it by a prescale factor and then by an 8-bit divider. While the enable input is high it emits a one-cycle conversion strobe once per programmed period. The period is set through a single 16-bit timer word written by a host, and the same word can be read back at any time.

The prescale code sits in bits 11:8 of the timer word. Codes 0 and 1 both divide by one, and any other code n divides by 2^n. The low byte does not hold the divider itself but its complement: the divider is 255 minus the stored byte. The period in base clocks is therefore the divider times the prescale factor, with a longest period of 255 × 2^15 cycles. Software picks the pair of values. The block only applies it.

Top module: `pacer_timer`

## Requirements
- R1: After reset the timer word reads back as 0xF000 (upper byte 0xF0, low byte 0x00) and the strobe is low.
- R2: A write stores bits 11:0 of the written word, and the read value shows them from the next cycle on. Bits 15:12 always read as 1 whatever is written. Without a write, the read value does not change.
- R3: Prescale code (bits 11:8) 0 and code 1 both give a prescale factor of 1, and code n for n from 2 to 15 gives a factor of 2^n.
- R4: The divider is 255 minus the low byte (bits 7:0). The strobe period in base clock cycles is the divider times the prescale factor.
- R5: A low byte of 0xFF gives a divider of 0, which acts as a divider of 1, so the period is never zero. With prescale factor 1 the strobe is then high in every enabled cycle.
- R6: The strobe lasts one cycle when the period exceeds one cycle. It is never high in a cycle that follows a clock edge at which enable was low.
- R7: When enable rises, the first strobe is visible in the cycle after the P-th clock edge at which enable is sampled high (P = period). Later strobes follow every P cycles.
- R8: A write reloads the prescaler and the divider counter at the clock edge after the write. No strobe comes from that edge, and a full new period is counted from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Writes wr_data_i into the timer word at this edge |
| wr_data_i | input | 16 | Timer word to write |
| enable_i | input | 1 | Runs the pacer while high. While low the counters are held at their reload values |
| rd_data_o | output | 16 | Current timer word |
| strobe_o | output | 1 | Conversion strobe |

## Verification
The bench goes after the edges of the period arithmetic. If codes 0 and 1 were decoded differently, the code-1 window would run at half the code-0 rate. A divider taken straight from the stored byte instead of its complement would give the wrong period for every value written. A low byte of 0xFF that was not clamped would either wrap to a 256-step count or stall the strobe, instead of pulsing every cycle. The first strobe after enable, the restart after a write made in the middle of a period, and a code-15 period of 32768 cycles are all compared cycle by cycle, so an off-by-one in the reload shows up as a strobe one edge early or late.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned PRESC_W = 4;
  localparam int unsigned DIV_W   = 8;
  localparam int unsigned PAD_W   = REG_W - PRESC_W - DIV_W;
  localparam int unsigned PCNT_W  = (1 << PRESC_W) - 1;

  typedef logic [PRESC_W-1:0] presc_code_t;
  typedef logic [DIV_W-1:0]   div_field_t;
  typedef logic [PCNT_W-1:0]  presc_cnt_t;

  localparam presc_code_t RST_CODE  = '0;
  localparam div_field_t  RST_FIELD = '0;

  // reload value for the prescaler: factor - 1, codes 0 and 1 both give 0
  function automatic presc_cnt_t presc_reload(presc_code_t code);
    logic [PCNT_W:0] f;
    if (code < presc_code_t'(2)) return '0;
    f = ((PCNT_W+1)'(1) << code) - (PCNT_W+1)'(1);
    return f[PCNT_W-1:0];
  endfunction

  // reload value for the divider: (max - field) - 1, a zero count acts as one
  function automatic div_field_t div_reload(div_field_t field);
    div_field_t cnt;
    cnt = ~field;
    if (cnt == '0) return '0;
    return cnt - div_field_t'(1);
  endfunction
endpackage

// File: rtl/pacer_regs.sv
module pacer_regs
  import pacer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output presc_code_t      code_o,
  output div_field_t       field_o,
  output logic             reload_o,
  output logic [REG_W-1:0] rd_data_o
);
  presc_code_t code_q;
  div_field_t  field_q;
  logic        pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= RST_CODE;
      field_q <= RST_FIELD;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= wr_en_i;
      if (wr_en_i) begin
        code_q  <= wr_data_i[DIV_W +: PRESC_W];
        field_q <= wr_data_i[DIV_W-1:0];
      end
    end
  end

  assign code_o    = code_q;
  assign field_o   = field_q;
  assign reload_o  = pend_q;
  assign rd_data_o = {{PAD_W{1'b1}}, code_q, field_q};
endmodule

// File: rtl/pacer_prescaler.sv
module pacer_prescaler
  import pacer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  presc_code_t code_i,
  output logic        tick_o
);
  presc_cnt_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= presc_reload(RST_CODE);
    end else if (load_i || cnt_q == '0) begin
      cnt_q <= presc_reload(code_i);
    end else begin
      cnt_q <= cnt_q - presc_cnt_t'(1);
    end
  end

  assign tick_o = !load_i && (cnt_q == '0);
endmodule

// File: rtl/pacer_divider.sv
module pacer_divider
  import pacer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       tick_i,
  input  div_field_t field_i,
  output logic       strobe_o
);
  div_field_t cnt_q;
  logic       strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= div_reload(RST_FIELD);
      strobe_q <= 1'b0;
    end else if (load_i) begin
      cnt_q    <= div_reload(field_i);
      strobe_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == '0) begin
        cnt_q    <= div_reload(field_i);
        strobe_q <= 1'b1;
      end else begin
        cnt_q    <= cnt_q - div_field_t'(1);
        strobe_q <= 1'b0;
      end
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;
endmodule

// File: rtl/pacer_timer.sv
module pacer_timer
  import pacer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             enable_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             strobe_o
);
  presc_code_t code;
  div_field_t  field;
  logic        reload;
  logic        load;
  logic        tick;

  pacer_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .code_o    (code),
    .field_o   (field),
    .reload_o  (reload),
    .rd_data_o (rd_data_o)
  );

  // counters sit at reload values while idle or right after a write
  assign load = reload || !enable_i;

  pacer_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .code_i (code),
    .tick_o (tick)
  );

  pacer_divider u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .tick_i   (tick),
    .field_i  (field),
    .strobe_o (strobe_o)
  );
endmodule

// File: rtl/pacer_timer_chk.sv
module pacer_timer_chk
  import pacer_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             enable_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             strobe_o
);
  logic period_one;
  assign period_one = (rd_data_o[DIV_W +: PRESC_W] < presc_code_t'(2)) &&
                      (rd_data_o[DIV_W-1:0] >= div_field_t'(8'hFE));

  AST_WRITE_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> rd_data_o[REG_W-PAD_W-1:0] == $past(wr_data_i[REG_W-PAD_W-1:0])); // R2

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> $stable(rd_data_o)); // R2

  AST_STROBE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(enable_i)); // R6

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !period_one) |=> !strobe_o); // R6

  AST_WRITE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i, 2) |-> !strobe_o); // R8
endmodule

bind pacer_timer pacer_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .enable_i  (enable_i),
  .rd_data_o (rd_data_o),
  .strobe_o  (strobe_o)
);

// File: tb/tb_pacer_timer.sv
`timescale 1ns/1ps
module tb_pacer_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        enable = 1'b0;
  logic [15:0] rd_data;
  logic        strobe;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  string phase = "R1";

  // reference model state
  logic [15:0] m_reg = 16'hF000;
  bit          m_pend = 1'b0;
  bit          m_strobe = 1'b0;
  int          m_elapsed = 0;

  always #4 clk = ~clk;

  pacer_timer dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .enable_i  (enable),
    .rd_data_o (rd_data),
    .strobe_o  (strobe)
  );

  function automatic int period_of(logic [15:0] r);
    int f, c;
    f = (r[11:8] < 2) ? 1 : (1 << r[11:8]);
    c = 255 - int'(r[7:0]);
    if (c == 0) c = 1;
    return f * c;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg = 16'hF000; m_pend = 0; m_strobe = 0; m_elapsed = 0;
    end else begin
      int p;
      p = period_of(m_reg);
      if (!enable || m_pend) begin
        m_elapsed = 0; m_strobe = 0;
      end else begin
        m_elapsed++;
        if (m_elapsed >= p) begin m_strobe = 1; m_elapsed = 0; end
        else m_strobe = 0;
      end
      m_pend = wr_en;
      if (wr_en) m_reg = {4'hF, wr_data[11:0]};
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      check({phase, " strobe"}, strobe, m_strobe);
      check("R2 readback", rd_data, m_reg);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      summary();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] v);
    wr_en = 1; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    cyc(2);
  endtask

  task automatic run_count(input string req, input int n, input int exp);
    int cnt = 0;
    enable = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (strobe) cnt++;
    end
    enable = 0;
    cyc(2);
    check(req, cnt, exp);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1;
    cyc(1);
    check("R1 reset word", rd_data, 16'hF000);
    check("R1 reset strobe", strobe, 0);

    phase = "R7";
    run_count("R7 default period 255", 600, 2);

    phase = "R4";
    write_word(16'h00FC);
    run_count("R4 divider 3", 30, 10);

    phase = "R3";
    write_word(16'h01FC);
    run_count("R3 code 1 divides by one", 30, 10);
    write_word(16'h02FC);
    run_count("R3 code 2 divides by four", 36, 3);

    phase = "R5";
    write_word(16'h00FF);
    run_count("R5 zero divider acts as one", 20, 20);
    write_word(16'h02FF);
    run_count("R5 zero divider with factor 4", 20, 5);

    phase = "R6";
    enable = 0;
    begin
      int cnt = 0;
      for (int i = 0; i < 50; i++) begin @(negedge clk); if (strobe) cnt++; end
      check("R6 no strobe while disabled", cnt, 0);
    end
    write_word(16'h00F8);
    enable = 1; cyc(5); enable = 0; cyc(3); enable = 1; cyc(9); enable = 0; cyc(3);

    phase = "R2";
    write_word(16'hA30F);
    check("R2 upper nibble reads ones", rd_data, 16'hF30F);

    phase = "R8";
    write_word(16'h02FC);
    enable = 1;
    cyc(7);
    wr_en = 1; wr_data = 16'h02FC;
    @(negedge clk);
    wr_en = 0;
    begin
      int first = -1;
      for (int i = 1; i <= 20; i++) begin
        @(negedge clk);
        if (strobe && first < 0) first = i;
      end
      // reload edge is the first after write; 12 further edges -> 13th negedge
      check("R8 restart after write", first, 13);
    end
    enable = 0; cyc(2);

    phase = "R3";
    write_word(16'h0FFE);
    run_count("R3 code 15 period 32768", 33000, 1);

    done = 1;
    summary();
  end
endmodule